// File: doc/BRIEF.md
# Interrupt Line State Tracker

This block keeps three flags for every line in a bank of interrupt sources: whether the line is allowed to be serviced (enable), whether a request is waiting (pending), and whether its handler is currently running (active). Each line has an active-high request input that is sampled on the rising clock edge. The same logic captures both single-cycle pulses and held levels, and no setting selects between the two kinds of source.

Software drives per-line strobe vectors that turn enable on or off and that set or clear pending. The interrupt controller drives an acknowledge strobe with a line index when it starts a handler, and an exit strobe with a line index when that handler returns. The block reports the enable, pending and active vectors, and a ready vector of lines that are pending, enabled and not active. Priority selection among ready lines is done outside this block.

Top module: `irq_line_tracker`

## Requirements
- R1: A request input that is high at a rising clock edge sets that line's pending flag from the next cycle on. A high pulse one cycle long is enough.
- R2: Once set, pending stays set after the request drops. It clears only on an acknowledge of that line or on a software clear-pending strobe.
- R3: Any number of request pulses that arrive before an acknowledge give a single pending event. One acknowledge leaves pending low when no request is present.
- R4: An acknowledge with `ack_valid` high and `ack_idx` equal to a line clears that line's pending and sets its active flag on the next cycle. The line is not ready while active.
- R5: A request that arrives while a line is active sets pending again. After an exit strobe for that line clears active, the line is ready on the next cycle if it is enabled.
- R6: A software set-pending strobe sets pending and a software clear-pending strobe clears it. When a clear-pending strobe and a high request meet at the same edge, the request wins and pending stays set.
- R7: If the request is still high when the handler exits, the line is pending again and becomes ready once active drops.
- R8: Pending can be set while the line is disabled. Enabling the line later makes it ready with no new request.
- R9: Synchronous active-low reset clears enable, pending and active for every line. While reset is held, requests do not set pending.
- R10: The enable-set strobe turns enable on and the enable-clear strobe turns it off. When both strobes hit the same line in one cycle, set wins.
- R11: Bit i of `ready_o` is high exactly when line i is pending, enabled and not active.
- R12: Acknowledge and exit act only on the indexed line. With their valid bit low they change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_LINES | Active-high request per line |
| sw_en_set | input | NUM_LINES | Software strobe: enable line |
| sw_en_clr | input | NUM_LINES | Software strobe: disable line |
| sw_pend_set | input | NUM_LINES | Software strobe: force pending |
| sw_pend_clr | input | NUM_LINES | Software strobe: drop pending |
| ack_valid | input | 1 | Handler-start strobe |
| ack_idx | input | IDX_W | Line index of the handler being started |
| exit_valid | input | 1 | Handler-return strobe |
| exit_idx | input | IDX_W | Line index of the handler returning |
| enable_o | output | NUM_LINES | Enable flag per line |
| pending_o | output | NUM_LINES | Pending flag per line |
| active_o | output | NUM_LINES | Active flag per line |
| ready_o | output | NUM_LINES | Pending, enabled and not active |

## Verification
Every flag is a register that drives an output directly, so a wrong internal state shows up at the ports in the first cycle after the edge that caused it. The bench compares all four vectors against a behavioural model on every cycle. A lost pulse or a pending flag that clears too early shows as a mismatch in `pending_o`. A wrong precedence between a software clear and a held request shows one cycle after the collision. An active flag that stays stuck shows as a `ready_o` bit that stays low after the exit.

// File: rtl/irq_track_pkg.sv
// Package: shared state type and helpers for the interrupt line tracker.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package irq_track_pkg;

    // Per-line flags, held together in one register
    typedef struct packed {
        logic en;
        logic pend;
        logic act;
    } line_state_t;

    // A line may be serviced when it waits, is allowed, and is not running
    function automatic logic line_ready(input line_state_t s);
        return s.pend & s.en & ~s.act;
    endfunction

endpackage

// File: rtl/irq_index_decode.sv
// Module: irq_index_decode
// Turns a strobe plus line index into a one-hot hit vector.
// Assumes: index values >= NUM_LINES produce no hit.
module irq_index_decode #(
    parameter int NUM_LINES = 32,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LINES-1:0] hit
);

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_hit
            // Compare the index against this line's position
            always_comb begin
                hit[g] = valid && (idx == IDX_W'(g));
            end
        end
    endgenerate

    // R12: a strobe never touches more than one line
    p_single_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R12: no hit without the valid bit
    p_no_hit_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (hit == '0));

endmodule

// File: rtl/irq_line_cell.sv
// Module: irq_line_cell
// Holds enable, pending and active for one interrupt line.
// Assumes: the request is synchronous to clk. When acknowledge and exit
// hit the same line in one cycle, acknowledge wins (back-to-back service).
module irq_line_cell
    import irq_track_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic en_set,
    input  logic en_clr,
    input  logic pend_set,
    input  logic pend_clr,
    input  logic ack_hit,
    input  logic exit_hit,
    output logic en_o,
    output logic pend_o,
    output logic act_o,
    output logic ready_o
);

    line_state_t st_q;
    line_state_t st_d;

    // Next-state rules for the three flags
    always_comb begin
        st_d = st_q;
        // enable: set wins over clear
        if (en_set) begin
            st_d.en = 1'b1;
        end else if (en_clr) begin
            st_d.en = 1'b0;
        end
        // pending: a request or a set wins over acknowledge and clear
        st_d.pend = req | pend_set | (st_q.pend & ~ack_hit & ~pend_clr);
        // active: acknowledge wins over exit
        if (ack_hit) begin
            st_d.act = 1'b1;
        end else if (exit_hit) begin
            st_d.act = 1'b0;
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Drive the outputs from the register
    always_comb begin
        en_o    = st_q.en;
        pend_o  = st_q.pend;
        act_o   = st_q.act;
        ready_o = line_ready(st_q);
    end

    // R1: a sampled request sets pending
    p_req_sets_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pend_o);

    // R2: pending holds unless acknowledged or cleared
    p_pend_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o && !ack_hit && !pend_clr |=> pend_o);

    // R4: acknowledge makes the line active
    p_ack_activates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> act_o && !ready_o);

    // R4: acknowledge with no new request empties pending
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit && !req && !pend_set |=> !pend_o);

    // R5: exit with no acknowledge releases the line
    p_exit_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exit_hit && !ack_hit |=> !act_o);

    // R6: a held request beats a software clear
    p_req_beats_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req && pend_clr |=> pend_o);

    // R10: set wins when both enable strobes arrive
    p_en_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> en_o);

    // R10: a lone clear disables the line
    p_en_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr && !en_set |=> !en_o);

endmodule

// File: rtl/irq_line_tracker.sv
// Module: irq_line_tracker (top)
// Bank of NUM_LINES interrupt line state cells, with index decoders for
// the controller's acknowledge and exit strobes.
// Assumes: strobes are single-cycle and synchronous to clk.
module irq_line_tracker #(
    parameter int NUM_LINES = 32,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic [NUM_LINES-1:0] sw_en_set,
    input  logic [NUM_LINES-1:0] sw_en_clr,
    input  logic [NUM_LINES-1:0] sw_pend_set,
    input  logic [NUM_LINES-1:0] sw_pend_clr,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    input  logic                 exit_valid,
    input  logic [IDX_W-1:0]     exit_idx,
    output logic [NUM_LINES-1:0] enable_o,
    output logic [NUM_LINES-1:0] pending_o,
    output logic [NUM_LINES-1:0] active_o,
    output logic [NUM_LINES-1:0] ready_o
);

    logic [NUM_LINES-1:0] ack_hit;
    logic [NUM_LINES-1:0] exit_hit;

    // Decode the handler-start index
    irq_index_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ack_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (ack_valid),
        .idx   (ack_idx),
        .hit   (ack_hit)
    );

    // Decode the handler-return index
    irq_index_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_exit_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (exit_valid),
        .idx   (exit_idx),
        .hit   (exit_hit)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            // One state cell per line
            irq_line_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (irq_req[g]),
                .en_set   (sw_en_set[g]),
                .en_clr   (sw_en_clr[g]),
                .pend_set (sw_pend_set[g]),
                .pend_clr (sw_pend_clr[g]),
                .ack_hit  (ack_hit[g]),
                .exit_hit (exit_hit[g]),
                .en_o     (enable_o[g]),
                .pend_o   (pending_o[g]),
                .act_o    (active_o[g]),
                .ready_o  (ready_o[g])
            );
        end
    endgenerate

    // R9: the cycle after a reset edge shows an empty bank
    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (enable_o == '0) && (pending_o == '0) && (active_o == '0));

    // R11: a ready line is never active and always enabled
    p_ready_subset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_o & (active_o | ~enable_o | ~pending_o)) == '0));

endmodule

// File: tb/irq_line_tracker_tb.sv
`timescale 1ns/1ps
module irq_line_tracker_tb;

    localparam int N    = 32;
    localparam int IW   = 5;
    localparam real TCK = 8.0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  irq_req, sw_en_set, sw_en_clr, sw_pend_set, sw_pend_clr;
    logic          ack_valid, exit_valid;
    logic [IW-1:0] ack_idx, exit_idx;
    logic [N-1:0]  enable_o, pending_o, active_o, ready_o;

    // reference model state
    bit m_en[N];
    bit m_pend[N];
    bit m_act[N];

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag      = "R9";

    always #(TCK/2) clk = ~clk;

    irq_line_tracker #(.NUM_LINES(N), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .sw_en_set(sw_en_set), .sw_en_clr(sw_en_clr),
        .sw_pend_set(sw_pend_set), .sw_pend_clr(sw_pend_clr),
        .ack_valid(ack_valid), .ack_idx(ack_idx),
        .exit_valid(exit_valid), .exit_idx(exit_idx),
        .enable_o(enable_o), .pending_o(pending_o),
        .active_o(active_o), .ready_o(ready_o)
    );

    task automatic model_update();
        for (int i = 0; i < N; i++) begin
            bit a, x;
            if (!rst_n) begin
                m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0;
            end else begin
                a = ack_valid  && (int'(ack_idx)  == i);
                x = exit_valid && (int'(exit_idx) == i);
                if (sw_en_set[i])      m_en[i] = 1;
                else if (sw_en_clr[i]) m_en[i] = 0;
                if (irq_req[i] || sw_pend_set[i]) m_pend[i] = 1;
                else if (a || sw_pend_clr[i])     m_pend[i] = 0;
                if (a)      m_act[i] = 1;
                else if (x) m_act[i] = 0;
            end
        end
    endtask

    task automatic check_vec(string name, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [N-1:0] e_en, e_pd, e_ac, e_rd;
        for (int i = 0; i < N; i++) begin
            e_en[i] = m_en[i];
            e_pd[i] = m_pend[i];
            e_ac[i] = m_act[i];
            e_rd[i] = m_pend[i] && m_en[i] && !m_act[i];
        end
        check_vec("enable",  enable_o,  e_en);
        check_vec("pending", pending_o, e_pd);
        check_vec("active",  active_o,  e_ac);
        check_vec("ready",   ready_o,   e_rd);
    endtask

    // one clock: model follows the edge, compare at the falling edge, drop strobes
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        sw_en_set = '0; sw_en_clr = '0; sw_pend_set = '0; sw_pend_clr = '0;
        ack_valid = 0; exit_valid = 0;
    endtask

    task automatic ack(int i);
        ack_valid = 1; ack_idx = IW'(i);
    endtask

    task automatic leave(int i);
        exit_valid = 1; exit_idx = IW'(i);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // watchdog
    initial begin
        #(TCK * 100000);
        n_fails++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; irq_req = '0; sw_en_set = '0; sw_en_clr = '0;
        sw_pend_set = '0; sw_pend_clr = '0;
        ack_valid = 0; exit_valid = 0; ack_idx = '0; exit_idx = '0;
        @(negedge clk);
        // R9: reset clears everything and ignores requests
        tag = "R9";
        irq_req = 32'h0000_00F0;
        repeat (3) step();
        irq_req = '0;
        rst_n = 1;
        step();

        // R10: enable set, set+clear together, lone clear
        tag = "R10";
        sw_en_set = (1 << 3) | (1 << 5) | (1 << 9) | (1 << 7);
        step();
        sw_en_set = 1 << 5; sw_en_clr = 1 << 5;
        step();
        sw_en_clr = 1 << 5;
        step();

        // R1: one-cycle pulse captured
        tag = "R1";
        irq_req[3] = 1; step();
        irq_req[3] = 0; step();
        // R2: pending stays without request
        tag = "R2";
        repeat (3) step();

        // R3: more pulses merge into one event
        tag = "R3";
        irq_req[3] = 1; step(); irq_req[3] = 0; step();
        irq_req[3] = 1; step(); irq_req[3] = 0; step();
        // R4: acknowledge moves pending to active
        tag = "R4";
        ack(3); step();
        step();
        // R5: request while active, then exit makes it ready again
        tag = "R5";
        irq_req[3] = 1; step(); irq_req[3] = 0; step();
        leave(3); step();
        step();
        ack(3); step();
        leave(3); step();

        // R6: software set and clear, clear colliding with held request
        tag = "R6";
        sw_pend_set = 1 << 7; step();
        sw_pend_clr = 1 << 7; step();
        irq_req[9] = 1; step();
        sw_pend_clr = 1 << 9; step();
        step();
        irq_req[9] = 0; sw_pend_clr = 1 << 9; step();

        // R7: level held through handler exit
        tag = "R7";
        irq_req[7] = 1; step();
        ack(7); step();
        leave(7); step();
        step();
        irq_req[7] = 0; ack(7); step();
        leave(7); step();

        // R8: pending while disabled, enable later
        tag = "R8";
        sw_pend_set = 1 << 12; step();
        step();
        sw_en_set = 1 << 12; step();

        // R12: strobes without valid, and indexed line only
        tag = "R12";
        ack_idx = 12; exit_idx = 12; step();
        ack(12); step();
        leave(3); step();
        leave(12); step();

        // R11: ready follows the three flags under mixed traffic
        tag = "R11";
        for (int c = 0; c < 600; c++) begin
            irq_req     = $urandom & $urandom & $urandom;
            sw_en_set   = $urandom & $urandom & $urandom;
            sw_en_clr   = $urandom & $urandom & $urandom & $urandom;
            sw_pend_set = $urandom & $urandom & $urandom & $urandom;
            sw_pend_clr = $urandom & $urandom & $urandom;
            ack_valid   = $urandom_range(0, 1);
            ack_idx     = IW'($urandom);
            exit_valid  = $urandom_range(0, 1);
            exit_idx    = IW'($urandom);
            step();
        end

        summary();
        $finish;
    end

endmodule